// File: doc/BRIEF.md
# Synthetic Packet Source with Flow Stop

This block produces test packets on a 32-bit word stream so that the downstream datapath can be exercised with nothing connected to its front end. Each packet starts with a four-word header. The payload that follows has a programmable number of words. Every packet carries an event number that rises by one from each packet to the next. A start-of-packet flag and an end-of-packet flag frame each packet, and a valid strobe qualifies every word.

The receiving FIFO can stop the flow with a flow-stop input. That input only acts while payload words are being sent. Once a header has begun it is always sent in full, so the FIFO must raise flow-stop while it still has room for at least one whole header.

When flow-stop is low the block sends one word per clock. The enable, the payload length and the idle gap between packets are taken in at the start of each packet. If enable is dropped, the block stops only after the current packet has finished.

Top module: `pktgen_top`

## Requirements
- R1: While reset is high and after it is released with enable low, `pkt_valid`, `pkt_sop` and `pkt_eop` are 0 and `pkt_data` is 0. The first packet after reset carries event number 0.
- R2: A header is four words, in this order: `32'hA5A5_0000 | CHANNEL`, the event number, the payload length in words (zero-extended), and the XOR of those three words.
- R3: Payload word n, counting from 0, equals `{event[15:0], n[15:0]}`.
- R4: `pkt_sop` is 1 only on the first header word. `pkt_eop` is 1 only on the last payload word, or on the fourth header word when the payload length is 0. Both flags are only ever 1 together with `pkt_valid`.
- R5: Each packet's event number is one more than the previous packet's.
- R6: In a payload cycle with `dst_xoff` high, no word is sent (`pkt_valid` = 0). The payload then resumes at the same word index.
- R7: `dst_xoff` has no effect on the header: the four header words appear on four consecutive cycles.
- R8: With `dst_xoff` low, one word is sent per clock, so EOP follows SOP by exactly 3 + length cycles.
- R9: While enable stays high, exactly `idle_gap` cycles (0 to 255) with `pkt_valid` low separate one packet's EOP from the next packet's SOP.
- R10: If enable is dropped during a packet, that packet still completes, and no further SOP follows while enable stays low.
- R11: Length and gap are sampled when a packet starts. Changing `pay_len` during a packet does not change that packet; the next packet uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_en | input | 1 | Enables packet generation; sampled at packet boundaries |
| pay_len | input | 16 | Payload length in words |
| idle_gap | input | GAP_W | Idle cycles inserted after each packet |
| dst_xoff | input | 1 | Flow stop from the receiving FIFO |
| pkt_valid | output | 1 | Word on `pkt_data` is valid |
| pkt_data | output | 32 | Stream word |
| pkt_sop | output | 1 | First word of a packet |
| pkt_eop | output | 1 | Last word of a packet |

## Verification
The assertions assume that `dst_xoff` and the configuration inputs change only between clock edges, and that `dst_xoff` is a plain level whose effect falls in the cycle where it is sampled. The bench drives every input at the falling edge and samples one time step later. It changes length and enable only inside a running packet or after the block has gone idle, which exercises the boundary-sampling rule without racing a packet start. Flow-stop patterns are placed on specific cycle offsets from SOP, covering both header cycles and payload cycles.

// File: rtl/pktgen_pkg.sv
package pktgen_pkg;

    localparam int WORD_W    = 32;
    localparam int LEN_W     = 16;
    localparam int EV_W      = 32;
    localparam int HDR_WORDS = 4;
    localparam int HIDX_W    = $clog2(HDR_WORDS);
    localparam logic [HIDX_W-1:0] HDR_LAST = HIDX_W'(HDR_WORDS - 1);
    localparam logic [15:0] START_TAG = 16'hA5A5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_GAP
    } gen_state_e;

    typedef struct packed {
        logic              valid;
        logic              sop;
        logic              eop;
        logic [WORD_W-1:0] data;
    } beat_t;

    function automatic logic [WORD_W-1:0] start_word(input logic [15:0] chan);
        return {START_TAG, chan};
    endfunction

    function automatic logic [WORD_W-1:0] hdr_sum(input logic [WORD_W-1:0] a,
                                                  input logic [WORD_W-1:0] b,
                                                  input logic [WORD_W-1:0] c);
        return a ^ b ^ c;
    endfunction

endpackage

// File: rtl/pktgen_hdr.sv
module pktgen_hdr
    import pktgen_pkg::*;
#(
    parameter logic [15:0] CHANNEL = 16'h0000
) (
    input  logic [HIDX_W-1:0] idx,
    input  logic [EV_W-1:0]   evid,
    input  logic [LEN_W-1:0]  len,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] w_start, w_ev, w_len;

    always_comb begin
        w_start = start_word(CHANNEL);
        w_ev    = WORD_W'(evid);
        w_len   = WORD_W'(len);
        unique case (idx)
            2'd0:    word = w_start;
            2'd1:    word = w_ev;
            2'd2:    word = w_len;
            default: word = hdr_sum(w_start, w_ev, w_len);
        endcase
    end
endmodule

// File: rtl/pktgen_seq.sv
module pktgen_seq
    import pktgen_pkg::*;
#(
    parameter int GAP_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [LEN_W-1:0]   len_in,
    input  logic [GAP_W-1:0]   gap_in,
    input  logic               xoff,
    output gen_state_e         state,
    output logic [HIDX_W-1:0]  hidx,
    output logic [LEN_W-1:0]   dcnt,
    output logic [LEN_W-1:0]   len_q,
    output logic [EV_W-1:0]    evid,
    output logic               pkt_end
);
    logic [GAP_W-1:0] gap_q, gcnt;
    logic last_hdr, last_data, gap_done, at_bound, do_start, to_gap, to_idle;

    always_comb begin
        last_hdr  = (state == ST_HDR) && (hidx == HDR_LAST);
        last_data = (state == ST_DATA) && !xoff && (dcnt == len_q - LEN_W'(1));
        pkt_end   = (last_hdr && (len_q == '0)) || last_data;
        gap_done  = (state == ST_GAP) && (gcnt <= GAP_W'(1));
        at_bound  = gap_done || (pkt_end && (gap_q == '0));
        do_start  = enable && ((state == ST_IDLE) || at_bound);
        to_gap    = pkt_end && (gap_q != '0);
        to_idle   = !enable && at_bound;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            hidx  <= '0;
            dcnt  <= '0;
            len_q <= '0;
            gap_q <= '0;
            gcnt  <= '0;
            evid  <= '0;
        end else begin
            if (do_start) begin
                state <= ST_HDR;
                hidx  <= '0;
                len_q <= len_in;
                gap_q <= gap_in;
            end else if (to_gap) begin
                state <= ST_GAP;
                gcnt  <= gap_q;
            end else if (to_idle) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_HDR: begin
                        if (hidx == HDR_LAST) begin
                            state <= ST_DATA;
                            dcnt  <= '0;
                        end else begin
                            hidx <= hidx + HIDX_W'(1);
                        end
                    end
                    ST_DATA: if (!xoff) dcnt <= dcnt + LEN_W'(1);
                    ST_GAP:  gcnt <= gcnt - GAP_W'(1);
                    default: ;
                endcase
            end
            if (pkt_end) evid <= evid + EV_W'(1);
        end
    end

    // R7
    hdr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HDR && hidx != HDR_LAST) |=>
        (state == ST_HDR && hidx == $past(hidx) + HIDX_W'(1)));

    // R6
    xoff_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && xoff) |=> (state == ST_DATA && $stable(dcnt)));

    // R5
    evid_step_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_end |=> (evid == $past(evid) + EV_W'(1)));

    // R11
    len_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && !pkt_end) |=> $stable(len_q));

    // R9
    gap_run_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP && gcnt > GAP_W'(1)) |=>
        (state == ST_GAP && gcnt == $past(gcnt) - GAP_W'(1)));
endmodule

// File: rtl/pktgen_top.sv
module pktgen_top
    import pktgen_pkg::*;
#(
    parameter logic [15:0] CHANNEL = 16'h0003,
    parameter int          GAP_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gen_en,
    input  logic [15:0]       pay_len,
    input  logic [GAP_W-1:0]  idle_gap,
    input  logic              dst_xoff,
    output logic              pkt_valid,
    output logic [31:0]       pkt_data,
    output logic              pkt_sop,
    output logic              pkt_eop
);
    gen_state_e        state;
    logic [HIDX_W-1:0] hidx;
    logic [LEN_W-1:0]  dcnt, len_q;
    logic [EV_W-1:0]   evid;
    logic              pkt_end;
    logic [WORD_W-1:0] hdr_word;
    beat_t             beat;

    pktgen_seq #(.GAP_W(GAP_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .enable  (gen_en),
        .len_in  (pay_len),
        .gap_in  (idle_gap),
        .xoff    (dst_xoff),
        .state   (state),
        .hidx    (hidx),
        .dcnt    (dcnt),
        .len_q   (len_q),
        .evid    (evid),
        .pkt_end (pkt_end)
    );

    pktgen_hdr #(.CHANNEL(CHANNEL)) u_hdr (
        .idx  (hidx),
        .evid (evid),
        .len  (len_q),
        .word (hdr_word)
    );

    always_comb begin
        beat = '0;
        unique case (state)
            ST_HDR: begin
                beat.valid = 1'b1;
                beat.sop   = (hidx == '0);
                beat.eop   = pkt_end;
                beat.data  = hdr_word;
            end
            ST_DATA: begin
                beat.valid = !dst_xoff;
                beat.eop   = pkt_end;
                beat.data  = dst_xoff ? '0 : {evid[15:0], dcnt[15:0]};
            end
            default: ;
        endcase
    end

    assign pkt_valid = beat.valid;
    assign pkt_data  = beat.data;
    assign pkt_sop   = beat.sop;
    assign pkt_eop   = beat.eop;

    // R4
    eop_valid_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_eop |-> (pkt_valid && !pkt_sop));

    // R4
    sop_valid_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_sop |-> pkt_valid);
endmodule

// File: tb/pktgen_top_tb.sv
module pktgen_top_tb;
    localparam logic [15:0] CH = 16'h0003;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gen_en = 1'b0;
    logic [15:0] pay_len = 16'd0;
    logic [7:0]  idle_gap = 8'd0;
    logic        dst_xoff = 1'b0;
    logic        pkt_valid, pkt_sop, pkt_eop;
    logic [31:0] pkt_data;

    pktgen_top #(.CHANNEL(CH), .GAP_W(8)) u_dut (
        .clk(clk), .rst(rst), .gen_en(gen_en), .pay_len(pay_len),
        .idle_gap(idle_gap), .dst_xoff(dst_xoff), .pkt_valid(pkt_valid),
        .pkt_data(pkt_data), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    int pkt_done = 0;
    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always begin
        @(negedge clk);
        #2;
        if (!rst && pkt_valid && pkt_eop) pkt_done++;
    end

    logic [31:0] cap_w [0:127];
    int cap_n, sop_cyc, eop_cyc, ev_at_sop, viol_x, hdr_break;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // xpat: flow-stop per cycle offset from SOP; cfg_at/new_len: change length at that offset;
    // drop_at: drop enable at that offset (-1 = none)
    task automatic collect(input logic [63:0] xpat, input int cfg_at,
                           input logic [15:0] new_len, input int drop_at);
        int k, waitc;
        bit done;
        cap_n = 0; viol_x = 0; hdr_break = 0; done = 0; waitc = 0;
        dst_xoff = 1'b0;
        do begin
            @(negedge clk); #1; waitc++;
        end while (!(pkt_valid && pkt_sop) && waitc < 600);
        if (waitc >= 600) begin
            chk(0, "R9", "no SOP seen", 0, 1);
            return;
        end
        sop_cyc = cyc; ev_at_sop = pkt_done;
        cap_w[0] = pkt_data; cap_n = 1;
        k = 1;
        while (!done && k < 300) begin
            @(negedge clk);
            dst_xoff = (k < 64) ? xpat[k] : 1'b0;
            if (k == cfg_at) pay_len = new_len;
            if (k == drop_at) gen_en = 1'b0;
            #1;
            if (pkt_valid) begin
                if (cap_n < 4 && k != cap_n) hdr_break++;
                if (cap_n >= 4 && dst_xoff) viol_x++;
                if (pkt_sop) hdr_break++;
                if (cap_n < 128) cap_w[cap_n] = pkt_data;
                cap_n++;
                if (pkt_eop) begin done = 1; eop_cyc = cyc; end
            end else if (cap_n < 4) begin
                hdr_break++;
            end
            k++;
        end
        dst_xoff = 1'b0;
    endtask

    task automatic check_packet(input int len, input string tag);
        logic [31:0] ev, w0, w2;
        ev = 32'(ev_at_sop);
        w0 = 32'hA5A5_0000 | 32'(CH);
        w2 = 32'(len);
        chk(cap_n == 4 + len, "R4", {tag, " word count"}, 32'(cap_n), 32'(4 + len));
        chk(cap_w[0] == w0, "R2", {tag, " start word"}, cap_w[0], w0);
        chk(cap_w[1] == ev, "R5", {tag, " event number"}, cap_w[1], ev);
        chk(cap_w[2] == w2, "R2", {tag, " length word"}, cap_w[2], w2);
        chk(cap_w[3] == (w0 ^ ev ^ w2), "R2", {tag, " checksum"}, cap_w[3], w0 ^ ev ^ w2);
        for (int n = 0; n < len && n + 4 < cap_n; n++)
            chk(cap_w[n + 4] == {ev[15:0], 16'(n)}, "R3", {tag, " payload"},
                cap_w[n + 4], {ev[15:0], 16'(n)});
        chk(hdr_break == 0, "R7", {tag, " header contiguity"}, 32'(hdr_break), 0);
    endtask

    task automatic quiesce();
        gen_en = 1'b0;
        dst_xoff = 1'b0;
        repeat (400) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk(!pkt_valid && !pkt_sop && !pkt_eop, "R1", "outputs in reset",
            {29'd0, pkt_valid, pkt_sop, pkt_eop}, 0);
        @(negedge clk); rst = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(!pkt_valid && !pkt_sop && !pkt_eop, "R1", "outputs idle after reset",
            {29'd0, pkt_valid, pkt_sop, pkt_eop}, 0);
        chk(pkt_data == 0, "R1", "data idle after reset", pkt_data, 0);
    endtask

    task automatic t_basic_and_gap();
        int prev_eop;
        logic [31:0] ev1;
        pay_len = 16'd5; idle_gap = 8'd3; gen_en = 1'b1;
        collect(64'd0, -1, 16'd0, -1);
        chk(ev_at_sop == 0, "R1", "first event number", 32'(ev_at_sop), 0);
        check_packet(5, "basic");
        chk(eop_cyc - sop_cyc == 8, "R8", "full-rate span", 32'(eop_cyc - sop_cyc), 8);
        prev_eop = eop_cyc; ev1 = cap_w[1];
        collect(64'd0, -1, 16'd0, -1);
        check_packet(5, "second");
        chk(sop_cyc - prev_eop - 1 == 3, "R9", "gap of 3", 32'(sop_cyc - prev_eop - 1), 3);
        chk(cap_w[1] == ev1 + 1, "R5", "event step", cap_w[1], ev1 + 1);
        quiesce();
        pay_len = 16'd2; idle_gap = 8'd0; gen_en = 1'b1;
        collect(64'd0, -1, 16'd0, -1);
        prev_eop = eop_cyc;
        collect(64'd0, -1, 16'd0, -1);
        check_packet(2, "gap0");
        chk(sop_cyc - prev_eop - 1 == 0, "R9", "gap of 0", 32'(sop_cyc - prev_eop - 1), 0);
        quiesce();
    endtask

    task automatic t_xoff_data();
        logic [63:0] p;
        p = '0; p[5] = 1; p[6] = 1; p[9] = 1;
        pay_len = 16'd6; idle_gap = 8'd2; gen_en = 1'b1;
        collect(p, -1, 16'd0, -1);
        check_packet(6, "xoff data");
        chk(viol_x == 0, "R6", "word sent under flow stop", 32'(viol_x), 0);
        chk(eop_cyc - sop_cyc == 12, "R6", "span with 3 stops", 32'(eop_cyc - sop_cyc), 12);
        quiesce();
    endtask

    task automatic t_xoff_hdr();
        logic [63:0] p;
        p = '0; p[1] = 1; p[2] = 1; p[3] = 1; p[4] = 1;
        pay_len = 16'd6; idle_gap = 8'd2; gen_en = 1'b1;
        collect(p, -1, 16'd0, -1);
        check_packet(6, "xoff header");
        chk(eop_cyc - sop_cyc == 10, "R7", "header ignores stop", 32'(eop_cyc - sop_cyc), 10);
        quiesce();
    endtask

    task automatic t_zero_len();
        pay_len = 16'd0; idle_gap = 8'd1; gen_en = 1'b1;
        collect(64'd0, -1, 16'd0, -1);
        check_packet(0, "zero length");
        chk(eop_cyc - sop_cyc == 3, "R4", "EOP on checksum word", 32'(eop_cyc - sop_cyc), 3);
        quiesce();
    endtask

    task automatic t_cfg_hold();
        pay_len = 16'd4; idle_gap = 8'd2; gen_en = 1'b1;
        collect(64'd0, 2, 16'd7, -1);
        check_packet(4, "R11 old length kept");
        collect(64'd0, -1, 16'd0, -1);
        check_packet(7, "R11 new length used");
        quiesce();
    endtask

    task automatic t_disable();
        int seen;
        pay_len = 16'd5; idle_gap = 8'd2; gen_en = 1'b1;
        collect(64'd0, -1, 16'd0, 6);
        check_packet(5, "R10 finishing packet");
        seen = 0;
        repeat (60) begin
            @(negedge clk); #1;
            if (pkt_valid) seen++;
        end
        chk(seen == 0, "R10", "no output after disable", 32'(seen), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        t_reset();
        t_basic_and_gap();
        t_xoff_data();
        t_xoff_hdr();
        t_zero_len();
        t_cfg_hold();
        t_disable();
        report();
    end
endmodule